// File: doc/BRIEF.md
# Ethernet Port Statistics Counter Bank

This block keeps the receive and transmit statistics of one Ethernet port. A frame parser elsewhere presents one end-of-frame event per direction per cycle: a valid strobe, the frame length in bytes and a flag vector. The bank then raises the matching counters. These are frame, byte, size-histogram, address-class, pause and error counters. Software reads them through a one-cycle registered read port. Every read clears the counter it returns, so a poller adds each value it reads to its own totals.

The byte counters are 45 bits wide and are read as two 32-bit words. Reading the low word clears the whole counter and parks its upper 13 bits in a snapshot register. A small state machine tracks whether that snapshot belongs to the receive side, the transmit side or neither:

- `HOLD_NONE`: no snapshot is held.
- `HOLD_RX`: a receive snapshot is held.
- `HOLD_TX`: a transmit snapshot is held.

The transitions are:

- `take_lo`: any state moves to `HOLD_RX` or `HOLD_TX` on a low-word read of that direction.
- `give_hi`: a held state moves to `HOLD_NONE` on a high-word read of the same direction.
- `wipe`: any state moves to `HOLD_NONE` on `clr_all`.

The receive maximum-length error counter uses only 31 bits. Its bit 31 carries the live receive-FIFO-empty status.

Top module: `rmon_stat_bank`

## Requirements
- R1: After reset every counter reads zero, `rd_vld` is 0 and `rd_data` is 0.
- R2: A read issued with `rd_en` high at a clock edge returns its data on `rd_data` with `rd_vld` high in the following cycle. `rd_vld` is low in any cycle whose previous edge had no read. `rd_addr[5]` selects the direction (0 receive, 1 transmit) and `rd_addr[4:0]` the slot:
  - Slots 0 to 2: 0 byte count low word, 1 byte count high word, 2 frames.
  - Slots 3 to 9 are the size bins: 3 exactly 64, 4 65-127, 5 128-255, 6 256-511, 7 512-1023, 8 1024-1518, 9 1519 and up.
  - Slots 10 to 12: 10 multicast, 11 broadcast, 12 pause.
  - Slot 13: FCS errors on receive, error frames on transmit.
  - Slots 14 to 18, receive only: 14 jabber, 15 short, 16 symbol errors, 17 oversize, 18 max-length errors.
  - Any other slot reads 0.
- R3: A read clears the counter it returns. An event arriving in the same cycle as the read is kept and shows on the next read.
- R4: Each valid event adds 1 to its direction's frame counter and adds the event length to its byte counter.
- R5: Each event adds 1 to exactly one size bin chosen by its length. A length below 64 adds to no bin.
- R6: Flag bits of `*_ev_flags` are:
  - bit 0 multicast, bit 1 broadcast, bit 2 pause, bit 3 FCS error;
  - bit 4 jabber, bit 5 symbol error, bit 6 oversize;
  - bit 7 max-length error, bit 8 underrun.

  On receive, each of multicast, broadcast, pause, FCS error, jabber, symbol error and oversize adds 1 to its own counter.
- R7: A receive event shorter than 64 bytes adds 1 to the receive short counter. Transmit keeps no short counter, so its slot 15 reads 0.
- R8: A transmit event adds 1 to the transmit multicast, broadcast and pause counters for the corresponding flags. It adds 1 to the transmit error counter when FCS error or underrun is set, and only 1 when both are set. Events of one direction never change the other direction's counters.
- R9: A low-word byte read returns bits 31:0 and holds bits 44:32. A following high-word read of the same direction returns the held bits in `rd_data[12:0]` and releases them. A high-word read with no held snapshot for that direction returns 0.
- R10: Receive slot 18 returns the max-length error count in bits 30:0. Bit 31 equals `rx_fifo_empty` in the read cycle and is not part of the count.
- R11: `clr_all` zeroes every counter of both directions at its clock edge. An event presented in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_all | input | 1 | Zero every counter |
| rx_ev_vld | input | 1 | Receive end-of-frame event |
| rx_ev_len | input | LEN_W | Receive frame length in bytes |
| rx_ev_flags | input | 9 | Receive event flags |
| tx_ev_vld | input | 1 | Transmit end-of-frame event |
| tx_ev_len | input | LEN_W | Transmit frame length in bytes |
| tx_ev_flags | input | 9 | Transmit event flags |
| rx_fifo_empty | input | 1 | Receive FIFO empty status |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 6 | Direction and slot |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
The bench targets four corner cases:

- **Read racing an event.** A counter that zeroes without adding the coincident increment would read one short on the next read.
- **Byte count past 2^32.** A bank that does not snapshot the upper bits, or clears them only on the high read, would return a wrong or stale high word. Reading the high word first, or twice, would then return nonzero data.
- **Exact histogram boundaries.** A design with an off-by-one boundary would place 64, 1518, 1519 or 511 in a neighbouring bin, or would count a 40-byte frame in a bin.
- **FIFO-status bit and error merging.** A design that counts into bit 31 would mix the status flag into the count. One that counts FCS error plus underrun twice would report an inflated transmit error total.

// File: rtl/rmon_pkg.sv
package rmon_pkg;

    typedef struct packed {
        logic underrun;
        logic maxlen_err;
        logic oversize;
        logic sym_err;
        logic jabber;
        logic fcs_err;
        logic pause;
        logic bcast;
        logic mcast;
    } rmon_flags_t;

    localparam int EV_N        = 16;
    localparam int TX_EV_N     = 12;
    localparam int SLOT_LO     = 0;
    localparam int SLOT_HI     = 1;
    localparam int EV_BASE     = 2;
    localparam int SLOT_MAXPKT = EV_BASE + EV_N;
    localparam logic [2:0] NO_BIN = 3'd7;

    typedef enum logic [1:0] {
        HOLD_NONE = 2'd0,
        HOLD_RX   = 2'd1,
        HOLD_TX   = 2'd2
    } hold_state_t;

    function automatic logic [2:0] size_bin(input logic [31:0] len);
        if (len < 32'd64)        return NO_BIN;
        else if (len == 32'd64)  return 3'd0;
        else if (len <= 32'd127) return 3'd1;
        else if (len <= 32'd255) return 3'd2;
        else if (len <= 32'd511) return 3'd3;
        else if (len <= 32'd1023) return 3'd4;
        else if (len <= 32'd1518) return 3'd5;
        else                     return 3'd6;
    endfunction

endpackage

// File: rtl/rmon_ctr.sv
module rmon_ctr #(
    parameter int W  = 32,
    parameter int AW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          rd_clr,
    input  logic          inc_en,
    input  logic [AW-1:0] inc_amt,
    output logic [W-1:0]  q
);
    logic [W-1:0] base;
    logic [W-1:0] add;

    always_comb begin
        base = rd_clr ? '0 : q;
        add  = inc_en ? W'(inc_amt) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) q <= '0;
        else                   q <= base + add;
    end

    // R11
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> q == '0);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && !rd_clr && !inc_en) |=> $stable(q));

    // R3
    rdclr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && rd_clr && inc_en) |=> q == W'($past(inc_amt)));
endmodule

// File: rtl/rmon_dir_bank.sv
module rmon_dir_bank
    import rmon_pkg::*;
#(
    parameter bit IS_RX    = 1'b1,
    parameter int LEN_W    = 16,
    parameter int CNT_W    = 32,
    parameter int BYTE_W   = 45,
    parameter int MAXPKT_W = 31,
    parameter int WORD_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_all,
    input  logic                     ev_vld,
    input  logic [LEN_W-1:0]         ev_len,
    input  rmon_flags_t              ev_flags,
    input  logic                     rd_clr,
    input  logic [4:0]               rd_slot,
    output logic [WORD_W-1:0]        rd_word,
    output logic [BYTE_W-WORD_W-1:0] byte_hi
);
    localparam int HI_W = BYTE_W - WORD_W;

    logic [2:0]        bin;
    logic [EV_N-1:0]   ev_inc;
    logic [CNT_W-1:0]  ev_q [EV_N];
    logic [BYTE_W-1:0] byte_q;
    logic [MAXPKT_W-1:0] maxpkt_q;
    logic [3:0]        ev_sel;

    assign bin = size_bin(32'(ev_len));

    always_comb begin
        ev_inc     = '0;
        ev_inc[0]  = ev_vld;
        for (int b = 0; b < 7; b++)
            ev_inc[1+b] = ev_vld && (bin == 3'(b));
        ev_inc[8]  = ev_vld && ev_flags.mcast;
        ev_inc[9]  = ev_vld && ev_flags.bcast;
        ev_inc[10] = ev_vld && ev_flags.pause;
        ev_inc[11] = ev_vld && (IS_RX ? ev_flags.fcs_err
                                      : (ev_flags.fcs_err || ev_flags.underrun));
        ev_inc[12] = ev_vld && ev_flags.jabber;
        ev_inc[13] = ev_vld && (ev_len < LEN_W'(64));
        ev_inc[14] = ev_vld && ev_flags.sym_err;
        ev_inc[15] = ev_vld && ev_flags.oversize;
    end

    for (genvar e = 0; e < EV_N; e++) begin : g_ev
        if (IS_RX || e < TX_EV_N) begin : g_on
            rmon_ctr #(.W(CNT_W), .AW(1)) u_ctr (
                .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
                .rd_clr(rd_clr && (rd_slot == 5'(EV_BASE + e))),
                .inc_en(ev_inc[e]), .inc_amt(1'b1), .q(ev_q[e]));
        end else begin : g_off
            assign ev_q[e] = '0;
        end
    end

    rmon_ctr #(.W(BYTE_W), .AW(LEN_W)) u_bytes (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
        .rd_clr(rd_clr && (rd_slot == 5'(SLOT_LO))),
        .inc_en(ev_vld), .inc_amt(ev_len), .q(byte_q));

    if (IS_RX) begin : g_maxpkt
        rmon_ctr #(.W(MAXPKT_W), .AW(1)) u_maxpkt (
            .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
            .rd_clr(rd_clr && (rd_slot == 5'(SLOT_MAXPKT))),
            .inc_en(ev_vld && ev_flags.maxlen_err), .inc_amt(1'b1),
            .q(maxpkt_q));
    end else begin : g_nomax
        assign maxpkt_q = '0;
    end

    assign ev_sel  = 4'(rd_slot - 5'(EV_BASE));
    assign byte_hi = byte_q[BYTE_W-1:WORD_W];

    always_comb begin
        rd_word = '0;
        if (rd_slot == 5'(SLOT_LO))
            rd_word = byte_q[WORD_W-1:0];
        else if (rd_slot >= 5'(EV_BASE) && rd_slot < 5'(SLOT_MAXPKT))
            rd_word = WORD_W'(ev_q[ev_sel]);
        else if (rd_slot == 5'(SLOT_MAXPKT))
            rd_word = WORD_W'(maxpkt_q);
    end

    // R5
    one_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev_inc[7:1]));

    // R7
    short_nobin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_inc[13] |-> (ev_inc[7:1] == '0));
endmodule

// File: rtl/rmon_stat_bank.sv
module rmon_stat_bank
    import rmon_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             rx_ev_vld,
    input  logic [LEN_W-1:0] rx_ev_len,
    input  logic [8:0]       rx_ev_flags,
    input  logic             tx_ev_vld,
    input  logic [LEN_W-1:0] tx_ev_len,
    input  logic [8:0]       tx_ev_flags,
    input  logic             rx_fifo_empty,
    input  logic             rd_en,
    input  logic [5:0]       rd_addr,
    output logic             rd_vld,
    output logic [31:0]      rd_data
);
    localparam int WORD_W = 32;
    localparam int BYTE_W = 45;
    localparam int HI_W   = BYTE_W - WORD_W;

    hold_state_t       state, state_nx;
    logic [HI_W-1:0]   snap;
    logic              dir;
    logic [4:0]        slot;
    logic              is_lo, is_hi;
    logic [WORD_W-1:0] rx_word, tx_word, mux;
    logic [HI_W-1:0]   rx_hi, tx_hi;

    assign dir   = rd_addr[5];
    assign slot  = rd_addr[4:0];
    assign is_lo = rd_en && (slot == 5'(SLOT_LO));
    assign is_hi = rd_en && (slot == 5'(SLOT_HI));

    rmon_dir_bank #(.IS_RX(1'b1), .LEN_W(LEN_W), .BYTE_W(BYTE_W),
                    .WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
        .ev_vld(rx_ev_vld), .ev_len(rx_ev_len), .ev_flags(rmon_flags_t'(rx_ev_flags)),
        .rd_clr(rd_en && !dir && !is_hi), .rd_slot(slot),
        .rd_word(rx_word), .byte_hi(rx_hi));

    rmon_dir_bank #(.IS_RX(1'b0), .LEN_W(LEN_W), .BYTE_W(BYTE_W),
                    .WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
        .ev_vld(tx_ev_vld), .ev_len(tx_ev_len), .ev_flags(rmon_flags_t'(tx_ev_flags)),
        .rd_clr(rd_en && dir && !is_hi), .rd_slot(slot),
        .rd_word(tx_word), .byte_hi(tx_hi));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            HOLD_NONE: if (is_lo) state_nx = dir ? HOLD_TX : HOLD_RX;
            HOLD_RX: begin
                if (is_lo)             state_nx = dir ? HOLD_TX : HOLD_RX;
                else if (is_hi && !dir) state_nx = HOLD_NONE;
            end
            HOLD_TX: begin
                if (is_lo)             state_nx = dir ? HOLD_TX : HOLD_RX;
                else if (is_hi && dir) state_nx = HOLD_NONE;
            end
            default: state_nx = HOLD_NONE;
        endcase
        if (clr_all) state_nx = HOLD_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= HOLD_NONE;
        else        state <= state_nx;
    end

    // read data selection
    always_comb begin
        if (slot == 5'(SLOT_HI))
            mux = ((state == HOLD_RX && !dir) || (state == HOLD_TX && dir))
                  ? WORD_W'(snap) : '0;
        else if (dir)
            mux = tx_word;
        else if (slot == 5'(SLOT_MAXPKT))
            mux = {rx_fifo_empty, rx_word[WORD_W-2:0]};
        else
            mux = rx_word;
    end

    // outputs and snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
            snap    <= '0;
        end else begin
            rd_vld  <= rd_en;
            rd_data <= rd_en ? mux : '0;
            if (clr_all)    snap <= '0;
            else if (is_lo) snap <= dir ? tx_hi : rx_hi;
        end
    end

    // R2
    rd_vld_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_vld);

    // R2
    rd_vld_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_vld);

    // R10
    fifo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 6'(SLOT_MAXPKT)) |=> rd_data[31] == $past(rx_fifo_empty));

    // R9
    hi_nohold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_hi && state == HOLD_NONE) |=> rd_data == '0);

    // R9
    hi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_hi && !is_lo && state == HOLD_RX && !dir) |=> state == HOLD_NONE);
endmodule

// File: tb/rmon_stat_bank_tb_top.sv
module rmon_stat_bank_tb_top;
    localparam int LEN_W = 16;
    localparam logic [8:0] MC = 9'h001, BC = 9'h002, PA = 9'h004, FC = 9'h008,
                           JB = 9'h010, SY = 9'h020, OV = 9'h040, ML = 9'h080,
                           UR = 9'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_all = 1'b0;
    logic rx_ev_vld = 1'b0, tx_ev_vld = 1'b0;
    logic [LEN_W-1:0] rx_ev_len = '0, tx_ev_len = '0;
    logic [8:0] rx_ev_flags = '0, tx_ev_flags = '0;
    logic rx_fifo_empty = 1'b0;
    logic rd_en = 1'b0;
    logic [5:0] rd_addr = '0;
    logic rd_vld;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    rmon_stat_bank #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
        .rx_ev_vld(rx_ev_vld), .rx_ev_len(rx_ev_len), .rx_ev_flags(rx_ev_flags),
        .tx_ev_vld(tx_ev_vld), .tx_ev_len(tx_ev_len), .tx_ev_flags(tx_ev_flags),
        .rx_fifo_empty(rx_fifo_empty), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_vld(rd_vld), .rd_data(rd_data));

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles %0d expected below 190000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        rd_en = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        checks++;
        if (rd_vld !== 1'b1) begin
            errors++;
            $display("FAIL R2: actual rd_vld %0b expected 1", rd_vld);
        end
        d = rd_data;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic send_rx(input int len, input logic [8:0] fl);
        rx_ev_vld = 1'b1; rx_ev_len = LEN_W'(len); rx_ev_flags = fl;
        @(negedge clk);
        rx_ev_vld = 1'b0; rx_ev_flags = '0;
    endtask

    task automatic send_tx(input int len, input logic [8:0] fl);
        tx_ev_vld = 1'b1; tx_ev_len = LEN_W'(len); tx_ev_flags = fl;
        @(negedge clk);
        tx_ev_vld = 1'b0; tx_ev_flags = '0;
    endtask

    task automatic pulse_clr();
        clr_all = 1'b1;
        @(negedge clk);
        clr_all = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rd_vld", 32'(rd_vld), 0);
        chk("R1 rd_data", rd_data, 0);
        rd_chk("R1 rx frames", 6'd2, 0);
        rd_chk("R1 tx bytes", 6'd32, 0);
        @(negedge clk);
        chk("R2 rd_vld idle", 32'(rd_vld), 0);
    endtask

    task automatic t_rx_basic();
        send_rx(100, MC);
        send_rx(64, BC);
        send_rx(1518, FC);
        send_rx(1519, PA);
        send_rx(40, 9'h000);
        rd_chk("R4 rx frames", 6'd2, 5);
        rd_chk("R4 rx bytes lo", 6'd0, 3241);
        rd_chk("R9 rx bytes hi", 6'd1, 0);
        rd_chk("R5 bin 64", 6'd3, 1);
        rd_chk("R5 bin 65-127", 6'd4, 1);
        rd_chk("R5 bin 128-255", 6'd5, 0);
        rd_chk("R5 bin 1024-1518", 6'd8, 1);
        rd_chk("R5 bin 1519+", 6'd9, 1);
        rd_chk("R7 rx short", 6'd15, 1);
        rd_chk("R6 rx mcast", 6'd10, 1);
        rd_chk("R6 rx bcast", 6'd11, 1);
        rd_chk("R6 rx pause", 6'd12, 1);
        rd_chk("R6 rx fcs", 6'd13, 1);
        rd_chk("R3 rx frames cleared", 6'd2, 0);
    endtask

    task automatic t_rx_flags2();
        send_rx(2000, JB | SY | OV | ML);
        rd_chk("R6 rx jabber", 6'd14, 1);
        rd_chk("R6 rx symerr", 6'd16, 1);
        rd_chk("R6 rx oversize", 6'd17, 1);
        rx_fifo_empty = 1'b1;
        rd_chk("R10 maxpkt with empty", 6'd18, 32'h8000_0001);
        rx_fifo_empty = 1'b0;
        rd_chk("R10 maxpkt cleared", 6'd18, 0);
        send_rx(70, ML);
        rd_chk("R10 maxpkt not empty", 6'd18, 1);
    endtask

    task automatic t_tx();
        send_tx(256, UR);
        send_tx(511, FC | UR);
        send_tx(300, MC | PA);
        rd_chk("R8 tx err", 6'd45, 2);
        rd_chk("R8 tx mcast", 6'd42, 1);
        rd_chk("R8 tx bcast", 6'd43, 0);
        rd_chk("R8 tx pause", 6'd44, 1);
        rd_chk("R5 tx bin 256-511", 6'd38, 3);
        rd_chk("R4 tx frames", 6'd34, 3);
        rd_chk("R4 tx bytes lo", 6'd32, 1067);
        rd_chk("R7 tx no short", 6'd47, 0);
        rd_chk("R8 rx untouched by tx", 6'd2, 2);
    endtask

    task automatic t_race();
        logic [31:0] d;
        pulse_clr();
        send_rx(80, 9'h000);
        send_rx(80, 9'h000);
        send_rx(80, 9'h000);
        rx_ev_vld = 1'b1; rx_ev_len = 16'd80;
        rd(6'd2, d);
        rx_ev_vld = 1'b0;
        chk("R3 read value at race", d, 3);
        rd_chk("R3 increment kept", 6'd2, 1);
    endtask

    task automatic t_clr_all();
        send_rx(90, MC);
        send_rx(90, MC);
        send_tx(90, 9'h000);
        clr_all = 1'b1; rx_ev_vld = 1'b1; rx_ev_len = 16'd90; rx_ev_flags = MC;
        @(negedge clk);
        clr_all = 1'b0; rx_ev_vld = 1'b0; rx_ev_flags = '0;
        rd_chk("R11 rx frames", 6'd2, 0);
        rd_chk("R11 rx bytes", 6'd0, 0);
        rd_chk("R11 rx mcast", 6'd10, 0);
        rd_chk("R11 tx frames", 6'd34, 0);
    endtask

    task automatic t_bytes_big();
        pulse_clr();
        rx_ev_vld = 1'b1; rx_ev_len = 16'hFFFF; rx_ev_flags = '0;
        repeat (65538) @(negedge clk);
        rx_ev_vld = 1'b0;
        rd_chk("R9 hi before lo", 6'd1, 0);
        rd_chk("R9 lo word", 6'd0, 65534);
        rd_chk("R9 tx hi not held", 6'd33, 0);
        rd_chk("R9 hi snapshot", 6'd1, 1);
        rd_chk("R9 hi released", 6'd1, 0);
        rd_chk("R9 lo cleared", 6'd0, 0);
        rd_chk("R4 big frames", 6'd2, 65538);
        rd_chk("R5 big bin", 6'd9, 65538);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_basic();
        t_rx_flags2();
        t_tx();
        t_race();
        t_clr_all();
        t_bytes_big();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule